// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block turns a 64-bit command write into a read-modify-write of one 32-bit word in another core's register space. A command arrives on one of two command offsets. The low word of the command carries a target core number, four byte-keep flags and, depending on the offset, either a mailbox slot index or a full 16-bit target address. The high word carries the new data.

For each byte lane whose keep flag is set, the block first reads the current word over a downstream 32-bit bus. It keeps that lane from the old contents and takes every other lane from the new data. When no keep flag is set, the read is skipped and the word is written whole. Every downstream request carries the target core's index as a tag.

While a command is in flight the block raises a stall, and it takes no further command. It reports one response per accepted command, flagged as an error when the target core does not exist or when the downstream read returns an error. A failed read aborts the command, so no write is issued.

Top module: `mbox_rmw_writer`

## Requirements
- R1: A command is taken only when `cmd_valid` is high, `cmd_is64` is high, `cmd_stall` is low and `cmd_addr` equals either the mailbox offset (default 12'h100) or the free-address offset (default 12'h158). Any other command produces no bus request, no response and no stall.
- R2: The target core number is command bits 25:16. A number not below NUM_CORES (default 4) yields a response with `resp_err` high and no bus request.
- R3: Keep flag i is command bit 27+i. For each set flag, byte i of the written word equals byte i of the word read. Every other byte equals the matching byte of command bits 63:32.
- R4: When bits 30:27 are all zero, no read is issued, and a single write carries command bits 63:32 unchanged.
- R5: On the mailbox offset, the target address is MBOX_BASE (default 16'h1000) + 16'h20 + (command AND 16'h1C).
- R6: On the free-address offset, the target address is command bits 15:0.
- R7: Each bus request carries the target core number as `bus_req_core`. The read comes before the write. A request holds its address, direction and tag until `bus_req_ready` is high.
- R8: `cmd_stall` is high from the cycle after a command is taken through the cycle of its response. No command is taken while it is high.
- R9: A read answered with `bus_rsp_err` high ends the command with `resp_err` high and no write.
- R10: Each taken command produces exactly one single-cycle `resp_valid` pulse. After reset, `cmd_stall`, `bus_req_valid` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_is64 | input | 1 | High when the write is a full 64-bit access |
| cmd_addr | input | 12 | Command offset |
| cmd_data | input | 64 | Command word |
| cmd_stall | output | 1 | Busy; no command is taken |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion failed (bad core or read error) |
| bus_req_valid | output | 1 | Downstream request valid |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | 16 | Downstream word address |
| bus_req_core | output | 2 | Target core tag ($clog2(NUM_CORES)) |
| bus_req_wdata | output | 32 | Merged write data |
| bus_req_ready | input | 1 | Downstream accepts the request |
| bus_rsp_valid | input | 1 | Read data valid |
| bus_rsp_err | input | 1 | Read failed |
| bus_rsp_rdata | input | 32 | Read data, little-endian |

## Verification
A sequencer stuck in a wrong state shows up within one clock as a mismatch between `cmd_stall` and the bench's own busy flag. It can also show up as a bus request the bench did not expect, or as a missing response. A wrongly latched keep mask or old word shows at the first write handshake, as a data mismatch in particular byte lanes. A read issued when no flag is set shows at that same handshake. A command taken while busy, or a write issued after a failed read, shows as an extra bus transaction in the same command window.

// File: rtl/mbox_rmw_pkg.sv
// Shared types for the byte-masked remote mailbox writer.
// Assumes a 32-bit downstream word split into four byte lanes.
package mbox_rmw_pkg;
    localparam int LANES  = 4;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/mbox_cmd_decode.sv
// Command decoder: splits a 64-bit command into target core, keep mask,
// new data and target address, and tells whether the offset is one of the
// two command ports. Purely combinational; assumes the core number equals
// the core index.
module mbox_cmd_decode #(
    parameter int          NUM_CORES = 4,
    parameter int          IDX_W     = 2,
    parameter logic [15:0] MBOX_BASE = 16'h1000,
    parameter logic [11:0] MAIL_OFS  = 12'h100,
    parameter logic [11:0] ANY_OFS   = 12'h158
) (
    input  logic             cmd_valid,
    input  logic             cmd_is64,
    input  logic [11:0]      cmd_addr,
    input  logic [63:0]      cmd_data,
    output logic             hit,
    output logic             core_ok,
    output logic [15:0]      tgt_addr,
    output logic [IDX_W-1:0] tgt_core,
    output logic [3:0]       keep_mask,
    output logic [31:0]      new_word
);
    localparam logic [31:0] NC_U = NUM_CORES;

    logic [9:0] core_id;
    logic       is_mail;
    logic       is_any;
    logic       unused_bits;

    // Field extraction from the command word.
    always_comb begin
        core_id   = cmd_data[25:16];
        keep_mask = cmd_data[30:27];
        new_word  = cmd_data[63:32];
        tgt_core  = core_id[IDX_W-1:0];
        core_ok   = ({22'd0, core_id} < NC_U);
    end

    // Port selection; only full 64-bit writes count.
    always_comb begin
        is_mail = cmd_valid && cmd_is64 && (cmd_addr == MAIL_OFS);
        is_any  = cmd_valid && cmd_is64 && (cmd_addr == ANY_OFS);
        hit     = is_mail || is_any;
    end

    // Target address per port rule.
    always_comb begin
        if (is_mail)
            tgt_addr = MBOX_BASE + 16'h0020 + {11'd0, cmd_data[4:2], 2'b00};
        else
            tgt_addr = cmd_data[15:0];
    end

    assign unused_bits = ^{cmd_data[26], cmd_data[31]};
endmodule

// File: rtl/mbox_byte_merge.sv
// Byte-lane merge: each lane takes the old byte when its keep flag is set,
// otherwise the new byte. Combinational.
module mbox_byte_merge #(
    parameter int LANES = mbox_rmw_pkg::LANES
) (
    input  logic [LANES*8-1:0] old_word,
    input  logic [LANES*8-1:0] new_word,
    input  logic [LANES-1:0]   keep,
    output logic [LANES*8-1:0] merged
);
    // One mux per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = keep[g] ? old_word[g*8 +: 8] : new_word[g*8 +: 8];
    end
endmodule

// File: rtl/mbox_rmw_seq.sv
// Read-modify-write sequencer: latches a taken command, issues an optional
// read, waits for its data, issues the write and pulses a response.
// Assumes at most one outstanding read and that writes need no response.
module mbox_rmw_seq
    import mbox_rmw_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_core_ok,
    input  logic [15:0]      start_addr,
    input  logic [IDX_W-1:0] start_core,
    input  logic [3:0]       start_keep,
    input  logic [31:0]      start_new,
    output logic             busy,
    output logic             resp_valid,
    output logic             resp_err,
    output logic [31:0]      old_q,
    output logic [31:0]      new_q,
    output logic [3:0]       keep_q,
    input  logic [31:0]      merged,
    output logic             bus_req_valid,
    output logic             bus_req_write,
    output logic [15:0]      bus_req_addr,
    output logic [IDX_W-1:0] bus_req_core,
    output logic [31:0]      bus_req_wdata,
    input  logic             bus_req_ready,
    input  logic             bus_rsp_valid,
    input  logic             bus_rsp_err,
    input  logic [31:0]      bus_rsp_rdata
);
    seq_state_t       state;
    logic [15:0]      addr_q;
    logic [IDX_W-1:0] core_q;
    logic             err_q;

    // State machine and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            core_q <= '0;
            keep_q <= '0;
            new_q  <= '0;
            old_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    addr_q <= start_addr;
                    core_q <= start_core;
                    keep_q <= start_keep;
                    new_q  <= start_new;
                    old_q  <= '0;
                    err_q  <= !start_core_ok;
                    if (!start_core_ok)       state <= ST_DONE;
                    else if (start_keep != 0) state <= ST_READ;
                    else                      state <= ST_WRITE;
                end
                ST_READ:  if (bus_req_ready) state <= ST_WAIT;
                ST_WAIT:  if (bus_rsp_valid) begin
                    if (bus_rsp_err) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        old_q <= bus_rsp_rdata;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: if (bus_req_ready) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state and latched fields.
    always_comb begin
        busy          = (state != ST_IDLE);
        resp_valid    = (state == ST_DONE);
        resp_err      = err_q;
        bus_req_valid = (state == ST_READ) || (state == ST_WRITE);
        bus_req_write = (state == ST_WRITE);
        bus_req_addr  = addr_q;
        bus_req_core  = core_q;
        bus_req_wdata = merged;
    end

    // R4: a read is only ever issued for a command with a keep flag set.
    a_r4_read_needs_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_write) |-> (keep_q != 4'd0));

    // R9: a read error goes straight to an error response with no write.
    a_r9_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && bus_rsp_valid && bus_rsp_err) |=>
        (resp_valid && resp_err && !bus_req_valid));

    // R7: a request not yet taken holds its fields.
    a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=>
        (bus_req_valid && $stable(bus_req_write) && $stable(bus_req_addr) && $stable(bus_req_core)));

    // R10: the response is a single-cycle pulse.
    a_r10_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
endmodule

// File: rtl/mbox_rmw_writer.sv
// Top of the byte-masked remote mailbox writer. Decodes commands on two
// offsets and runs one read-modify-write per taken command downstream.
// Assumes core numbers below NUM_CORES map one-to-one to core indices.
module mbox_rmw_writer #(
    parameter int          NUM_CORES = 4,
    parameter logic [15:0] MBOX_BASE = 16'h1000,
    parameter logic [11:0] MAIL_OFS  = 12'h100,
    parameter logic [11:0] ANY_OFS   = 12'h158,
    localparam int         IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_is64,
    input  logic [11:0]      cmd_addr,
    input  logic [63:0]      cmd_data,
    output logic             cmd_stall,
    output logic             resp_valid,
    output logic             resp_err,
    output logic             bus_req_valid,
    output logic             bus_req_write,
    output logic [15:0]      bus_req_addr,
    output logic [IDX_W-1:0] bus_req_core,
    output logic [31:0]      bus_req_wdata,
    input  logic             bus_req_ready,
    input  logic             bus_rsp_valid,
    input  logic             bus_rsp_err,
    input  logic [31:0]      bus_rsp_rdata
);
    logic             hit;
    logic             core_ok;
    logic [15:0]      tgt_addr;
    logic [IDX_W-1:0] tgt_core;
    logic [3:0]       keep_mask;
    logic [31:0]      new_word;
    logic             accept;
    logic [31:0]      old_q;
    logic [31:0]      new_q;
    logic [3:0]       keep_q;
    logic [31:0]      merged;

    mbox_cmd_decode #(
        .NUM_CORES(NUM_CORES),
        .IDX_W    (IDX_W),
        .MBOX_BASE(MBOX_BASE),
        .MAIL_OFS (MAIL_OFS),
        .ANY_OFS  (ANY_OFS)
    ) u_dec (
        .cmd_valid(cmd_valid),
        .cmd_is64 (cmd_is64),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .hit      (hit),
        .core_ok  (core_ok),
        .tgt_addr (tgt_addr),
        .tgt_core (tgt_core),
        .keep_mask(keep_mask),
        .new_word (new_word)
    );

    // A command is taken only while idle.
    assign accept = hit && !cmd_stall;

    mbox_rmw_seq #(.IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .start_core_ok(core_ok),
        .start_addr   (tgt_addr),
        .start_core   (tgt_core),
        .start_keep   (keep_mask),
        .start_new    (new_word),
        .busy         (cmd_stall),
        .resp_valid   (resp_valid),
        .resp_err     (resp_err),
        .old_q        (old_q),
        .new_q        (new_q),
        .keep_q       (keep_q),
        .merged       (merged),
        .bus_req_valid(bus_req_valid),
        .bus_req_write(bus_req_write),
        .bus_req_addr (bus_req_addr),
        .bus_req_core (bus_req_core),
        .bus_req_wdata(bus_req_wdata),
        .bus_req_ready(bus_req_ready),
        .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_err  (bus_rsp_err),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    mbox_byte_merge #(.LANES(4)) u_merge (
        .old_word(old_q),
        .new_word(new_q),
        .keep    (keep_q),
        .merged  (merged)
    );

    // R2: an unknown core is answered with an error at once.
    a_r2_bad_core: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !core_ok) |=> (resp_valid && resp_err && !bus_req_valid));

    // R8: while stalled, the next cycle is still busy or completing.
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stall && !resp_valid) |=> cmd_stall);
endmodule

// File: tb/tb_mbox_rmw_writer.sv
module tb_mbox_rmw_writer;
    localparam int          NC   = 4;
    localparam logic [11:0] MOFS = 12'h100;
    localparam logic [11:0] AOFS = 12'h158;
    localparam logic [15:0] BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is64 = 1'b0;
    logic [11:0] cmd_addr = '0;
    logic [63:0] cmd_data = '0;
    logic        cmd_stall, resp_valid, resp_err;
    logic        bus_req_valid, bus_req_write;
    logic [15:0] bus_req_addr;
    logic [1:0]  bus_req_core;
    logic [31:0] bus_req_wdata;
    logic        bus_req_ready = 1'b0;
    logic        bus_rsp_valid = 1'b0;
    logic        bus_rsp_err = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;

    always #2 clk = ~clk;

    mbox_rmw_writer #(.NUM_CORES(NC), .MBOX_BASE(BASE), .MAIL_OFS(MOFS), .ANY_OFS(AOFS)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is64(cmd_is64),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_stall(cmd_stall),
        .resp_valid(resp_valid), .resp_err(resp_err), .bus_req_valid(bus_req_valid),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_core(bus_req_core), .bus_req_wdata(bus_req_wdata),
        .bus_req_ready(bus_req_ready), .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_err(bus_rsp_err), .bus_rsp_rdata(bus_rsp_rdata)
    );

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [1:0]  core;
        logic [31:0] data;
    } xact_t;

    xact_t       expq[$];
    logic [31:0] mem [int];
    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    int          resp_cnt = 0;
    bit          mbusy = 0;
    bit          acc_last = 0;
    bit          exp_err = 0;
    bit          inj_err = 0;
    bit          rsp_pend = 0;
    bit          rsp_err_pend = 0;
    logic [31:0] rsp_data_pend = '0;
    string       cur_tag = "";

    function automatic logic [31:0] mem_rd(int key);
        if (mem.exists(key)) return mem[key];
        return 32'h5A00_0000 | 32'(key[23:0]) ^ 32'h0033_C3C3;
    endfunction

    function automatic logic [31:0] merge_ref(logic [31:0] o, logic [31:0] n, logic [3:0] k);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = k[i] ? o[i*8 +: 8] : n[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One clock of reference model, bus responder and comparison.
    task automatic tick();
        bit    r;
        xact_t e;
        int    key;
        @(negedge clk);
        cyc++;
        if (acc_last) begin mbusy = 1; acc_last = 0; end
        chk(cmd_stall === mbusy, "R8 stall vs model busy", 64'(cmd_stall), 64'(mbusy));
        if (resp_valid === 1'b1) begin
            resp_cnt++;
            chk(resp_err === exp_err, {cur_tag, " resp_err"}, 64'(resp_err), 64'(exp_err));
            mbusy = 0;
        end
        bus_rsp_valid = rsp_pend;
        bus_rsp_err   = rsp_err_pend;
        bus_rsp_rdata = rsp_data_pend;
        rsp_pend      = 0;
        r = (cyc % 3) != 1;
        bus_req_ready = r;
        if (bus_req_valid === 1'b1 && r) begin
            key = int'(bus_req_core) * 65536 + int'(bus_req_addr);
            if (expq.size() == 0) begin
                chk(0, {cur_tag, " R7 unexpected bus request"},
                    {bus_req_write, 13'd0, bus_req_core, bus_req_addr, bus_req_wdata}, 64'd0);
            end else begin
                e = expq.pop_front();
                chk(bus_req_write === e.wr && bus_req_addr === e.addr && bus_req_core === e.core &&
                    (!e.wr || bus_req_wdata === e.data), {cur_tag, " R7 bus request"},
                    {bus_req_write, 13'd0, bus_req_core, bus_req_addr, e.wr ? bus_req_wdata : 32'd0},
                    {e.wr, 13'd0, e.core, e.addr, e.wr ? e.data : 32'd0});
            end
            if (!bus_req_write) begin
                rsp_pend      = 1;
                rsp_err_pend  = inj_err;
                rsp_data_pend = mem_rd(key);
            end else begin
                mem[key] = bus_req_wdata;
            end
        end
    endtask

    // Issue one command, predict its effect and follow it to completion.
    task automatic send(logic [11:0] a, bit is64, logic [63:0] d, bit err, bit hold, string tag);
        bit          acc;
        int          id;
        int          key;
        int          rc0;
        int          n;
        logic [15:0] ta;
        logic [3:0]  k;
        xact_t       x;
        while (cmd_stall) tick();
        cur_tag = tag;
        inj_err = err;
        acc = is64 && (a == MOFS || a == AOFS);
        id  = int'(d[25:16]);
        k   = d[30:27];
        ta  = (a == MOFS) ? (BASE + 16'h20 + (d[15:0] & 16'h001C)) : d[15:0];
        exp_err = 0;
        if (acc) begin
            if (id >= NC) begin
                exp_err = 1;
            end else begin
                key = id * 65536 + int'(ta);
                if (k != 0) begin
                    x.wr = 0; x.addr = ta; x.core = 2'(id); x.data = '0;
                    expq.push_back(x);
                end
                if (err && k != 0) begin
                    exp_err = 1;
                end else begin
                    x.wr = 1; x.addr = ta; x.core = 2'(id);
                    x.data = merge_ref(mem_rd(key), d[63:32], k);
                    expq.push_back(x);
                end
            end
        end
        rc0       = resp_cnt;
        cmd_valid = 1; cmd_is64 = is64; cmd_addr = a; cmd_data = d;
        acc_last  = acc;
        tick();
        if (hold) cmd_data = {32'hDEAD_BEEF, 32'h0001_0004};
        else      cmd_valid = 0;
        n = 0;
        while (acc && resp_cnt == rc0 && n < 60) begin tick(); n++; end
        cmd_valid = 0;
        repeat (3) tick();
        chk(expq.size() == 0, {tag, " all predicted bus requests seen"}, 64'(expq.size()), 64'd0);
        chk(resp_cnt == rc0 + (acc ? 1 : 0), {tag, " R10 response count"},
            64'(resp_cnt - rc0), acc ? 64'd1 : 64'd0);
        expq.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!cmd_stall && !bus_req_valid && !resp_valid, "R10 reset state",
            {61'd0, cmd_stall, bus_req_valid, resp_valid}, 64'd0);
        // R4 R5: mailbox offset, no keep flags, core 1, slot bits 4:2 = 3.
        send(MOFS, 1, {32'h1122_3344, 32'h0001_000C}, 0, 0, "R4 R5 mail no-read");
        // R3 R5 R7: keep lanes 0 and 2, core 2.
        send(MOFS, 1, {32'hAABB_CCDD, 32'h2802_0014}, 0, 0, "R3 R5 mail keep 0101");
        // R6 R3: free address, keep all lanes, core 0.
        send(AOFS, 1, {32'hFFFF_FFFF, 32'h7800_2468}, 0, 0, "R6 R3 any keep 1111");
        // R6 R3: keep lane 1 only, core 3, same word twice to see persistence.
        send(AOFS, 1, {32'h0102_0304, 32'h1003_1F00}, 0, 0, "R6 R3 any keep 0010");
        send(AOFS, 1, {32'hF0E0_D0C0, 32'h4003_1F00}, 0, 0, "R3 any keep 1000 after write");
        // R2: unknown cores.
        send(MOFS, 1, {32'h1234_5678, 32'h0004_0000}, 0, 0, "R2 core 4 missing");
        send(AOFS, 1, {32'h1234_5678, 32'h7BFF_0010}, 0, 0, "R2 core 1023 missing");
        // R1: wrong offset and narrow write are ignored.
        send(12'h108, 1, {32'h1234_5678, 32'h0001_0000}, 0, 0, "R1 other offset ignored");
        send(MOFS, 0, {32'h1234_5678, 32'h0001_0000}, 0, 0, "R1 32-bit write ignored");
        // R9: read error aborts; R4: no read means no error path.
        send(AOFS, 1, {32'h5555_5555, 32'h0802_0040}, 1, 0, "R9 read error aborts");
        send(AOFS, 1, {32'h6666_6666, 32'h0002_0040}, 1, 0, "R4 R9 no read no error");
        // R8: command held valid while busy is not taken.
        send(MOFS, 1, {32'h0BAD_F00D, 32'h3001_0008}, 0, 1, "R8 held command while busy");
        send(MOFS, 1, {32'h0BAD_F00D, 32'h0006_0000}, 0, 1, "R8 R2 held after bad core");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule